// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Routing

This block holds every digital divider that surrounds a frequency synthesizer core. A fixed prescaler brings the reference clock down by sixteen before the phase comparison point. A programmable feedback counter divides the oscillator by M, and a toggle stage halves that again, so a locked loop runs the oscillator at reference/16 × 2M. An output divider takes the oscillator down by 1, 2, 4 or 8 with an even duty cycle, and a three-bit test code picks which internal node drives a single-ended test pin.

All logic runs on one common clock. Each source clock is represented by a tick enable, and one tick stands for one transition of that source (one half period). A divide-by-N output therefore toggles every N ticks, and the feedback counter counts rising transitions only: the first tick after reset, then every second tick. When the test code selects scan operation, the serial-clock ticks replace the oscillator ticks for both the feedback counter and the output divider. The test pin then shows the serial clock divided by M and by 2, and the main output shows the serial clock divided by N.

Top module: `synth_divchain`

## Requirements
- R1: The prescaler output starts low after reset and toggles on every 16th reference tick. It is visible on test_out under code 010.
- R2: Under code 011, test_out shows the feedback stage. It starts low and toggles on every Mth rising source transition (the odd-numbered source ticks after reset). A new m_val takes effect only at the next terminal count. An m_val of 0 behaves as 1.
- R3: The n_code sets the number of source ticks between main_out toggles: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 1. The result is a divide-by-N output with equal high and low times.
- R4: A new n_code is adopted only when main_out rises, and it then governs both halves of that period. After reset, main_out first rises on the first source tick.
- R5: Under code 000, test_out equals shift_out in the same cycle.
- R6: Under code 001, test_out is constantly high. Under code 101, it is constantly low.
- R7: Under code 100, test_out equals main_out. Under code 111, test_out starts low and toggles on every second rising edge of main_out, which gives main_out divided by 4.
- R8: Under code 110, both the feedback stage and the output divider advance on sclk_ce only, and vco_ce has no effect. test_out shows the feedback stage.
- R9: Under every code except 110, both dividers advance on vco_ce only, and sclk_ce has no effect. main_out always shows the output divider.
- R10: While reset is applied, main_out is low, and test_out is low under code 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common simulation clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vco_ce | input | 1 | Oscillator transition tick |
| ref_ce | input | 1 | Reference clock transition tick |
| sclk_ce | input | 1 | Serial clock transition tick |
| m_val | input | 9 | Feedback divide value M |
| n_code | input | 2 | Output divider code |
| t_code | input | 3 | Test routing code |
| shift_out | input | 1 | Serial shift register output bit |
| test_out | output | 1 | Single-ended test pin |
| main_out | output | 1 | Divided main output |

## Verification
The hardest situations to reach are changes that arrive part-way through a count. These are an n_code change in the middle of a half period, an m_val change between reloads, and a switch into or out of scan operation while oscillator ticks keep arriving. The stimulus drives sparse random ticks on all three sources and changes the configuration at cycle counts that are not aligned to any divider boundary. It uses small M values, including 0 and 1, so that many reloads and boundary decisions occur in a short run.

// File: rtl/synth_divchain_pkg.sv
package synth_divchain_pkg;

  typedef enum logic [2:0] {
    TM_SHIFT = 3'b000,
    TM_HIGH  = 3'b001,
    TM_REF   = 3'b010,
    TM_FB    = 3'b011,
    TM_OUT   = 3'b100,
    TM_LOW   = 3'b101,
    TM_SCAN  = 3'b110,
    TM_OUT4  = 3'b111
  } test_mode_e;

  localparam int OUT_CNT_W = 3;

  // ticks per half period minus one, per output divider code
  function automatic logic [OUT_CNT_W-1:0] half_len_m1(input logic [1:0] code);
    case (code)
      2'b00:   half_len_m1 = OUT_CNT_W'(1);
      2'b01:   half_len_m1 = OUT_CNT_W'(3);
      2'b10:   half_len_m1 = OUT_CNT_W'(7);
      default: half_len_m1 = OUT_CNT_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/synth_divchain_prescale.sv
module synth_divchain_prescale #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic div_o
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_q, div_d;

  always_comb begin
    cnt_d = cnt_q;
    div_d = div_q;
    if (tick) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) div_d = ~div_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/synth_divchain_fbdiv.sv
module synth_divchain_fbdiv #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [M_W-1:0] m_val,
  output logic           half_o
);
  logic [M_W-1:0] cnt_q, cnt_d;
  logic           phase_q, phase_d;
  logic           half_q, half_d;
  logic [M_W-1:0] reload;
  logic           rise;
  logic           term;

  assign reload = (m_val == '0) ? '0 : m_val - 1'b1;
  assign rise   = tick && !phase_q;
  assign term   = rise && (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    half_d  = half_q;
    if (tick) phase_d = ~phase_q;
    if (term) begin
      cnt_d  = reload;
      half_d = ~half_q;
    end else if (rise) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
      half_q  <= 1'b0;
    end else if (tick) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      half_q  <= half_d;
    end
  end

  assign half_o = half_q;
endmodule

// File: rtl/synth_divchain_outdiv.sv
module synth_divchain_outdiv
  import synth_divchain_pkg::*;
#(
  parameter int POST_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] n_code,
  output logic       out_o,
  output logic       post_o
);
  logic [OUT_CNT_W-1:0] cnt_q, cnt_d;
  logic                 out_q, out_d;
  logic [1:0]           nact_q, nact_d;
  logic [POST_W-1:0]    post_q, post_d;
  logic                 edge_hit;

  assign edge_hit = tick && (cnt_q == half_len_m1(nact_q));

  always_comb begin
    cnt_d  = cnt_q;
    out_d  = out_q;
    nact_d = nact_q;
    post_d = post_q;
    if (edge_hit) begin
      cnt_d = '0;
      out_d = ~out_q;
      if (!out_q) begin
        nact_d = n_code;
        post_d = post_q + 1'b1;
      end
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      out_q  <= 1'b0;
      nact_q <= 2'b11;
      post_q <= '0;
    end else if (tick) begin
      cnt_q  <= cnt_d;
      out_q  <= out_d;
      nact_q <= nact_d;
      post_q <= post_d;
    end
  end

  assign out_o  = out_q;
  assign post_o = post_q[POST_W-1];
endmodule

// File: rtl/synth_divchain_testmux.sv
module synth_divchain_testmux
  import synth_divchain_pkg::*;
(
  input  test_mode_e mode,
  input  logic       shift_bit,
  input  logic       ref_div,
  input  logic       fb_half,
  input  logic       out_div,
  input  logic       out_div4,
  output logic       test_o
);
  always_comb begin
    case (mode)
      TM_SHIFT: test_o = shift_bit;
      TM_HIGH:  test_o = 1'b1;
      TM_REF:   test_o = ref_div;
      TM_FB:    test_o = fb_half;
      TM_OUT:   test_o = out_div;
      TM_LOW:   test_o = 1'b0;
      TM_SCAN:  test_o = fb_half;
      default:  test_o = out_div4;
    endcase
  end
endmodule

// File: rtl/synth_divchain.sv
module synth_divchain
  import synth_divchain_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int REF_LOG2 = 4,
  parameter int POST_W   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_ce,
  input  logic           ref_ce,
  input  logic           sclk_ce,
  input  logic [M_W-1:0] m_val,
  input  logic [1:0]     n_code,
  input  logic [2:0]     t_code,
  input  logic           shift_out,
  output logic           test_out,
  output logic           main_out
);
  logic [1:0] rs_q;
  logic       core_rst_n;
  test_mode_e mode;
  logic       div_tick;
  logic       ref_div, fb_half, out_div, out_div4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign core_rst_n = rs_q[1];

  assign mode     = test_mode_e'(t_code);
  assign div_tick = (mode == TM_SCAN) ? sclk_ce : vco_ce;

  synth_divchain_prescale #(.CNT_W(REF_LOG2)) u_pre (
    .clk(clk), .rst_n(core_rst_n), .tick(ref_ce), .div_o(ref_div)
  );

  synth_divchain_fbdiv #(.M_W(M_W)) u_fb (
    .clk(clk), .rst_n(core_rst_n), .tick(div_tick), .m_val(m_val), .half_o(fb_half)
  );

  synth_divchain_outdiv #(.POST_W(POST_W)) u_out (
    .clk(clk), .rst_n(core_rst_n), .tick(div_tick), .n_code(n_code),
    .out_o(out_div), .post_o(out_div4)
  );

  synth_divchain_testmux u_mux (
    .mode(mode), .shift_bit(shift_out), .ref_div(ref_div), .fb_half(fb_half),
    .out_div(out_div), .out_div4(out_div4), .test_o(test_out)
  );

  assign main_out = out_div;
endmodule

// File: rtl/synth_divchain_chk.sv
module synth_divchain_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vco_ce,
  input logic       ref_ce,
  input logic       sclk_ce,
  input logic [2:0] t_code,
  input logic       shift_out,
  input logic       test_out,
  input logic       main_out
);
  // R9: outside scan, main_out moves only on an oscillator tick
  assert_vco_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code != 3'b110 && !vco_ce) |=> $stable(main_out));

  // R8: in scan, main_out moves only on a serial tick
  assert_sclk_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b110 && !sclk_ce) |=> $stable(main_out));

  // R1: prescaler output on test pin holds without a reference tick
  assert_ref_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b010 && !ref_ce) ##1 (t_code == 3'b010) |-> $stable(test_out));

  // R6: constant levels
  assert_const_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b001) |-> test_out);
  assert_const_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b101) |-> !test_out);

  // R5: shift register bit passes straight through
  assert_shift_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (t_code == 3'b000) |-> (test_out == shift_out));
endmodule

bind synth_divchain synth_divchain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vco_ce(vco_ce), .ref_ce(ref_ce), .sclk_ce(sclk_ce),
  .t_code(t_code), .shift_out(shift_out), .test_out(test_out), .main_out(main_out)
);

// File: tb/synth_divchain_bench.sv
`timescale 1ns/1ps
module synth_divchain_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vco_ce = 1'b0, ref_ce = 1'b0, sclk_ce = 1'b0;
  logic [8:0] m_val = 9'd3;
  logic [1:0] n_code = 2'b00;
  logic [2:0] t_code = 3'b010;
  logic       shift_out = 1'b0;
  logic       test_out, main_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit ticking = 0;

  always #5 clk = ~clk;

  synth_divchain u_synth_divchain (
    .clk(clk), .rst_n(rst_n), .vco_ce(vco_ce), .ref_ce(ref_ce), .sclk_ce(sclk_ce),
    .m_val(m_val), .n_code(n_code), .t_code(t_code), .shift_out(shift_out),
    .test_out(test_out), .main_out(main_out)
  );

  // behavioural reference model
  int ref_cnt, fb_cnt, since, nact, post;
  bit ref_lvl, fb_phase, fb_half, out_lvl;

  function automatic int n_len(input int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 8;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt = 0; ref_lvl = 0; fb_cnt = 0; fb_phase = 0; fb_half = 0;
      since = 0; out_lvl = 0; nact = 3; post = 0;
    end else begin
      bit tk;
      tk = (t_code == 3'b110) ? sclk_ce : vco_ce;
      if (ref_ce) begin
        ref_cnt++;
        if (ref_cnt == 16) begin ref_cnt = 0; ref_lvl = !ref_lvl; end
      end
      if (tk) begin
        if (!fb_phase) begin
          if (fb_cnt == 0) begin
            fb_cnt = (m_val == 0) ? 0 : int'(m_val) - 1;
            fb_half = !fb_half;
          end else fb_cnt--;
        end
        fb_phase = !fb_phase;
        if (since == n_len(nact) - 1) begin
          since = 0;
          if (!out_lvl) begin nact = int'(n_code); post = (post + 1) % 4; end
          out_lvl = !out_lvl;
        end else since++;
      end
    end
  end

  function automatic bit exp_test();
    case (t_code)
      3'b000: return shift_out;
      3'b001: return 1'b1;
      3'b010: return ref_lvl;
      3'b011: return fb_half;
      3'b100: return out_lvl;
      3'b101: return 1'b0;
      3'b110: return fb_half;
      default: return post >= 2;
    endcase
  endfunction

  function automatic string test_tag();
    case (t_code)
      3'b000: return "R5";
      3'b001, 3'b101: return "R6";
      3'b010: return "R1";
      3'b011: return "R2";
      3'b110: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge, then new inputs
  task automatic run(input int cycles, input int vp, input int rp, input int sp);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(test_out, exp_test(), test_tag(), "test_out");
      check(main_out, out_lvl, (t_code == 3'b110) ? "R8" : "R3,R4,R9", "main_out");
      vco_ce    = ticking && (($urandom % 100) < vp);
      ref_ce    = ticking && (($urandom % 100) < rp);
      sclk_ce   = ticking && (($urandom % 100) < sp);
      shift_out = $urandom % 2;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    check(main_out, 1'b0, "R10", "main_out in reset");
    check(test_out, 1'b0, "R10", "prescaler on test_out in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    ticking = 1;
    run(600, 60, 70, 40);                             // R1 prescaler
    t_code = 3'b011; m_val = 9'd3;  run(500, 70, 30, 40);  // R2
    m_val = 9'd5;                    run(300, 50, 30, 40);  // R2 change mid count
    m_val = 9'd0;                    run(200, 60, 30, 40);  // R2 M=0
    m_val = 9'd1;                    run(200, 60, 30, 40);
    t_code = 3'b100;
    for (int n = 0; n < 4; n++) begin                 // R3 all codes, R4 unaligned change
      n_code = 2'(n); run(173 + 11 * n, 55, 20, 50);
    end
    n_code = 2'b10; run(90, 100, 20, 50);
    n_code = 2'b11; run(37, 100, 20, 50);
    t_code = 3'b111; n_code = 2'b01; run(600, 70, 20, 50); // R7
    n_code = 2'b11; run(300, 40, 20, 50);
    t_code = 3'b000; run(200, 50, 50, 50);           // R5
    t_code = 3'b001; run(100, 50, 50, 50);           // R6
    t_code = 3'b101; run(100, 50, 50, 50);           // R6
    t_code = 3'b110; m_val = 9'd4; n_code = 2'b00; run(600, 90, 20, 30); // R8
    n_code = 2'b01; run(300, 90, 20, 60);
    t_code = 3'b100; run(300, 30, 20, 90);           // R9 serial ticks ignored
    t_code = 3'b011; m_val = 9'd7; run(400, 50, 20, 90);
    t_code = 3'b010; run(400, 20, 80, 90);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule